// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four reset causes into a single active-low system reset for a processor subsystem. The causes are a power-on or brownout request, a watchdog expiry, a low level on a shared reset pin, and a software reset request. The software request is honoured only while a programming-enable level is high. The reset pin is open-drain and bidirectional. The block samples it as an input, and for every internally caused reset it pulls the pin low for a fixed number of cycles. Its own pulse is hidden from the input path, so it cannot trigger a second reset.

In run mode the pin passes through a synchroniser and must stay low for a minimum run of cycles before it counts as a reset. In stop mode the system clock is stopped, so a low pin asserts reset at once without any clock edge. Reset always asserts asynchronously. Release always passes through a clocked synchroniser.

A sticky watchdog flag records a watchdog-caused reset. Only software or power-on clears it. A small oscillator-selection register is also held here and only power-on clears it, so the same oscillator is used again after a watchdog reset. The restart fetch address is supplied as a constant output.

Top module: `rstc_top`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` is low and `pin_drive_low` is high without waiting for a clock edge. After `por_n` rises, the pin pulse ends and `sys_rst_n` goes high within 8 cycles.
- R2: `restart_addr` always equals 16'h8000.
- R3: In run mode, the pin held low for 4 or more consecutive clock cycles causes a system reset. A low run of 3 cycles causes none.
- R4: The system reset stays asserted for as long as the pin stays low. It deasserts no later than the 4th rising clock edge after the pin returns high.
- R5: With `stop_mode` high and no clock running, a low pin drives `sys_rst_n` low immediately.
- R6: A one-cycle `wdt_expire` drives `pin_drive_low` high for exactly 4 consecutive cycles, starting the cycle after, and asserts the system reset.
- R7: A one-cycle `sw_rst_req` with `sw_prog_en` high acts like a watchdog pulse and system reset. With `sw_prog_en` low the request is ignored: no pin drive and no system reset.
- R8: `wdt_flag` becomes 1 after a watchdog expiry. No system reset clears it; `wflag_clr` clears it, and power-on clears it to 0.
- R9: `osc_cfg` takes `osc_wdata` when `osc_we` is high. It keeps its value through watchdog, software and external resets, and only power-on clears it to 0.
- R10: The block's own pin pulse is never taken as an external reset. After an internal pulse, `sys_rst_n` returns high and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on/brownout request, active low, asynchronous |
| stop_mode | input | 1 | High when the system clock is stopped |
| pin_in | input | 1 | Sampled level of the shared reset pin |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the pin low |
| wdt_expire | input | 1 | Watchdog timeout strobe |
| sw_rst_req | input | 1 | Software reset request strobe |
| sw_prog_en | input | 1 | Programming-enable level that qualifies the software request |
| wflag_clr | input | 1 | Software clear of the watchdog flag |
| osc_we | input | 1 | Write strobe for the oscillator selection |
| osc_wdata | input | OSC_W | Oscillator selection write data |
| osc_cfg | output | OSC_W | Oscillator selection, cleared only by power-on |
| wdt_flag | output | 1 | Sticky watchdog-reset flag |
| sys_rst_n | output | 1 | System reset to core and peripherals, active low |
| restart_addr | output | 16 | Fetch address after reset |

## Verification
The bench drives the pin low for exactly 3 and exactly 4 cycles. A filter off by one either misses the 4-cycle run or fires on the 3-cycle glitch. It loops the open-drain output back onto the pin input. A design that fails to hide its own pulse would then reset itself again and again, and `sys_rst_n` would never settle high. It stops the clock in stop mode to show that reset can only arrive through the asynchronous path. It also checks that the flag and the oscillator selection survive non-power-on resets, which catches a design that ties them to the system reset.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam logic [15:0] RESTART_VEC_DEF = 16'h8000;

   typedef struct packed {
      logic wdt;
      logic sw;
   } int_req_t;
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LOW     = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_i,
   input  logic mask_i,
   output logic ext_req_o
);
   localparam int unsigned CW = $clog2(MIN_LOW);
   localparam logic [CW-1:0] CMAX = CW'(MIN_LOW - 1);

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW < 2) begin : g_chk_min
      $error("MIN_LOW must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;
   logic                   low_s;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   assign low_s = ~sync_q[SYNC_STAGES-1] & ~mask_i;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)           run_q <= '0;
      else if (!low_s)      run_q <= '0;
      else if (run_q != CMAX) run_q <= run_q + 1'b1;
   end

   assign ext_req_o = low_s && (run_q == CMAX);

   // R10: a masked cycle restarts the run, so no request follows it
   p_mask_blocks_r10: assert property (@(posedge clk) disable iff (!por_n)
      $past(mask_i) |-> !ext_req_o);
endmodule

// File: rtl/rstc_pulse_gen.sv
module rstc_pulse_gen #(
   parameter int unsigned PULSE_CYC   = 4,
   parameter int unsigned MASK_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic trig_i,
   output logic drive_o,
   output logic mask_o
);
   localparam int unsigned PW = $clog2(PULSE_CYC + 1);
   localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC);

   if (PULSE_CYC < 1) begin : g_chk_pulse
      $error("PULSE_CYC must be at least 1");
   end

   logic [PW-1:0]          cnt_q;
   logic [MASK_STAGES-1:0] hist_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)           cnt_q <= PLOAD;
      else if (trig_i)      cnt_q <= PLOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign drive_o = (cnt_q != '0);

   generate
      if (MASK_STAGES == 1) begin : g_hist1
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) hist_q <= '1;
            else        hist_q <= drive_o;
         end
      end else begin : g_histn
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) hist_q <= '1;
            else        hist_q <= {hist_q[MASK_STAGES-2:0], drive_o};
         end
      end
   endgenerate

   assign mask_o = drive_o | (|hist_q);

   // R6: a trigger starts the pin pulse on the next cycle
   p_trig_drives_r6: assert property (@(posedge clk) disable iff (!por_n)
      trig_i |=> drive_o);
endmodule

// File: rtl/rstc_rel_sync.sv
module rstc_rel_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic hold_i,
   output logic rst_n_o
);
   if (STAGES < 2) begin : g_chk_stages
      $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)     ff_q <= '0;
      else if (hold_i) ff_q <= '0;
      else             ff_q <= {ff_q[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = ff_q[STAGES-1];

   // R4: a held request keeps the output in reset on the next cycle
   p_hold_asserts_r4: assert property (@(posedge clk) disable iff (!arst_n)
      hold_i |=> !rst_n_o);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
   import rstc_pkg::*;
#(
   parameter int unsigned OSC_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned EXT_MIN_LOW = 4,
   parameter int unsigned PULSE_CYC   = 4,
   parameter bit          ASYNC_STOP  = 1'b1,
   parameter logic [15:0] RESTART_VEC = RESTART_VEC_DEF
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             stop_mode,
   input  logic             pin_in,
   output logic             pin_drive_low,
   input  logic             wdt_expire,
   input  logic             sw_rst_req,
   input  logic             sw_prog_en,
   input  logic             wflag_clr,
   input  logic             osc_we,
   input  logic [OSC_W-1:0] osc_wdata,
   output logic [OSC_W-1:0] osc_cfg,
   output logic             wdt_flag,
   output logic             sys_rst_n,
   output logic [15:0]      restart_addr
);
   if (OSC_W < 1) begin : g_chk_osc
      $error("OSC_W must be at least 1");
   end

   int_req_t req;
   logic     int_trig, ext_req, mask, hold, arst_n;

   assign req.wdt  = wdt_expire;
   assign req.sw   = sw_rst_req & sw_prog_en;
   assign int_trig = |req;

   rstc_pulse_gen #(.PULSE_CYC(PULSE_CYC), .MASK_STAGES(SYNC_STAGES)) u_pulse (
      .clk(clk), .por_n(por_n), .trig_i(int_trig),
      .drive_o(pin_drive_low), .mask_o(mask));

   rstc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(EXT_MIN_LOW)) u_filt (
      .clk(clk), .por_n(por_n), .pin_i(pin_in), .mask_i(mask), .ext_req_o(ext_req));

   generate
      if (ASYNC_STOP) begin : g_stop_async
         assign arst_n = por_n & ~(stop_mode & ~pin_in & ~pin_drive_low);
      end else begin : g_stop_none
         logic unused_stop;
         assign unused_stop = stop_mode;
         assign arst_n = por_n;
      end
   endgenerate

   assign hold = ext_req | pin_drive_low;

   rstc_rel_sync #(.STAGES(SYNC_STAGES)) u_rel (
      .clk(clk), .arst_n(arst_n), .hold_i(hold), .rst_n_o(sys_rst_n));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          wdt_flag <= 1'b0;
      else if (req.wdt)    wdt_flag <= 1'b1;
      else if (wflag_clr)  wdt_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      osc_cfg <= '0;
      else if (osc_we) osc_cfg <= osc_wdata;
   end

   assign restart_addr = RESTART_VEC;

   // R8: a watchdog expiry sets the flag
   p_flag_set_r8: assert property (@(posedge clk) disable iff (!por_n)
      wdt_expire |=> wdt_flag);
   // R3: an accepted external request pulls the system reset low
   p_ext_resets_r3: assert property (@(posedge clk) disable iff (!por_n)
      ext_req |=> !sys_rst_n);
   // R7: a request without programming enable starts no pulse
   p_sw_gated_r7: assert property (@(posedge clk) disable iff (!por_n)
      (sw_rst_req && !sw_prog_en && !wdt_expire && !pin_drive_low) |=> !pin_drive_low);
   // R9: without a write the oscillator selection holds
   p_osc_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
      !osc_we |=> $stable(osc_cfg));
endmodule

// File: tb/rstc_top_bench.sv
module rstc_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int OSC_W = 3;

   logic clk = 1'b0, clk_run = 1'b1;
   logic por_n, stop_mode, ext_low, wdt_expire, sw_rst_req, sw_prog_en;
   logic wflag_clr, osc_we;
   logic [OSC_W-1:0] osc_wdata, osc_cfg;
   logic pin_drive_low, wdt_flag, sys_rst_n, pin_line;
   logic [15:0] restart_addr;
   int checks = 0, errors = 0;

   assign pin_line = ~(ext_low | pin_drive_low);

   rstc_top #(.OSC_W(OSC_W)) u_rstc_top (
      .clk(clk), .por_n(por_n), .stop_mode(stop_mode), .pin_in(pin_line),
      .pin_drive_low(pin_drive_low), .wdt_expire(wdt_expire),
      .sw_rst_req(sw_rst_req), .sw_prog_en(sw_prog_en), .wflag_clr(wflag_clr),
      .osc_we(osc_we), .osc_wdata(osc_wdata), .osc_cfg(osc_cfg),
      .wdt_flag(wdt_flag), .sys_rst_n(sys_rst_n), .restart_addr(restart_addr));

   initial forever begin
      #(CLK_PERIOD/2);
      if (clk_run || clk) clk = ~clk;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle_high(input string req);
      int k = 0;
      while (!sys_rst_n && k < 20) begin cyc(1); k++; end
      chk(sys_rst_n == 1'b1, req, sys_rst_n, 1);
   endtask

   task automatic t_por;
      int k;
      por_n = 1'b0;
      #1;
      chk(sys_rst_n == 1'b0, "R1", sys_rst_n, 0);
      chk(pin_drive_low == 1'b1, "R1", pin_drive_low, 1);
      chk(wdt_flag == 1'b0, "R8", wdt_flag, 0);
      chk(osc_cfg == '0, "R9", osc_cfg, 0);
      cyc(2);
      por_n = 1'b1;
      k = 0;
      while (!sys_rst_n && k < 20) begin cyc(1); k++; end
      chk(k <= 8 && !pin_drive_low, "R1", k, 8);
      chk(restart_addr == 16'h8000, "R2", restart_addr, 'h8000);
   endtask

   task automatic t_ext_glitch;
      bit seen = 0;
      ext_low = 1'b1; cyc(3); ext_low = 1'b0;
      repeat (10) begin cyc(1); if (!sys_rst_n) seen = 1; end
      chk(!seen, "R3", seen, 0);
   endtask

   task automatic t_ext_min;
      bit seen = 0;
      ext_low = 1'b1; cyc(4); ext_low = 1'b0;
      repeat (10) begin cyc(1); if (!sys_rst_n) seen = 1; end
      chk(seen, "R3", seen, 1);
      settle_high("R3");
   endtask

   task automatic t_ext_hold;
      int k = 0;
      ext_low = 1'b1; cyc(25);
      chk(sys_rst_n == 1'b0, "R4", sys_rst_n, 0);
      ext_low = 1'b0;
      while (!sys_rst_n && k < 20) begin cyc(1); k++; end
      chk(k <= 4, "R4", k, 4);
      chk(osc_cfg == 3'b101, "R9", osc_cfg, 5);
      chk(wdt_flag == 1'b1, "R8", wdt_flag, 1);
   endtask

   task automatic t_wdt;
      int drv = 0; bit seen = 0; bit stay = 1;
      osc_we = 1'b1; osc_wdata = 3'b101; cyc(1); osc_we = 1'b0;
      wdt_expire = 1'b1; cyc(1); wdt_expire = 1'b0;
      chk(pin_drive_low == 1'b1, "R6", pin_drive_low, 1);
      drv = 1;
      repeat (12) begin
         cyc(1);
         if (pin_drive_low) drv++;
         if (!sys_rst_n) seen = 1;
      end
      chk(drv == 4, "R6", drv, 4);
      chk(seen, "R6", seen, 1);
      chk(wdt_flag == 1'b1, "R8", wdt_flag, 1);
      chk(osc_cfg == 3'b101, "R9", osc_cfg, 5);
      repeat (20) begin cyc(1); if (!sys_rst_n) stay = 0; end
      chk(stay, "R10", stay, 1);
   endtask

   task automatic t_sw;
      int drv = 0; bit seen = 0;
      sw_prog_en = 1'b0; sw_rst_req = 1'b1; cyc(1); sw_rst_req = 1'b0;
      repeat (10) begin cyc(1); if (pin_drive_low) drv++; if (!sys_rst_n) seen = 1; end
      chk(drv == 0 && !seen, "R7", drv + int'(seen), 0);
      sw_prog_en = 1'b1; sw_rst_req = 1'b1; cyc(1); sw_rst_req = 1'b0;
      drv = 1; seen = 0;
      chk(pin_drive_low == 1'b1, "R7", pin_drive_low, 1);
      repeat (12) begin cyc(1); if (pin_drive_low) drv++; if (!sys_rst_n) seen = 1; end
      chk(drv == 4 && seen, "R7", drv, 4);
      sw_prog_en = 1'b0;
      settle_high("R10");
      chk(osc_cfg == 3'b101, "R9", osc_cfg, 5);
   endtask

   task automatic t_flag_clr;
      wflag_clr = 1'b1; cyc(1); wflag_clr = 1'b0;
      chk(wdt_flag == 1'b0, "R8", wdt_flag, 0);
   endtask

   task automatic t_stop;
      stop_mode = 1'b1; clk_run = 1'b0;
      #(CLK_PERIOD*2);
      ext_low = 1'b1;
      #1;
      chk(sys_rst_n == 1'b0, "R5", sys_rst_n, 0);
      #(CLK_PERIOD);
      ext_low = 1'b0; stop_mode = 1'b0; clk_run = 1'b1;
      cyc(1);
      settle_high("R5");
   endtask

   task automatic t_por_clears;
      wdt_expire = 1'b1; cyc(1); wdt_expire = 1'b0; cyc(12);
      por_n = 1'b0; #1;
      chk(wdt_flag == 1'b0, "R8", wdt_flag, 0);
      chk(osc_cfg == '0, "R9", osc_cfg, 0);
      cyc(1); por_n = 1'b1;
      settle_high("R1");
   endtask

   initial begin
      por_n = 1'b0; stop_mode = 1'b0; ext_low = 1'b0; wdt_expire = 1'b0;
      sw_rst_req = 1'b0; sw_prog_en = 1'b0; wflag_clr = 1'b0;
      osc_we = 1'b0; osc_wdata = '0;
      cyc(1);
      t_por();
      t_ext_glitch();
      t_ext_min();
      t_wdt();
      t_ext_hold();
      t_sw();
      t_flag_clr();
      t_stop();
      t_por_clears();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule